// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides the power state of a contactless reader front end. It chooses among four states: full operation, a hard power-down forced by a dedicated pin, a standby state entered by software, and a start-up state that counts a fixed settling time before the block reports ready again. A separate bit turns the radio transmitter and receiver off without changing any other power state. The analog regulators, the oscillator and the RF modem are not part of the block. It only drives their enable outputs.

Software sets a standby bit to enter standby and clears it to leave. A wake byte arriving on the UART host port while in standby also ends standby. Releasing the power-down pin starts the same start-up count. The count is given in clock cycles and defaults to 15 µs at the configured clock. A host can find out when the block is ready by polling a status read: the read gets no answer until the start-up count has finished.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After rst_ni is released the block is in start-up: reg_en_o, osc_en_o and lfo_en_o are 1, ready_o is 0, and ready_o becomes 1 exactly STARTUP_CYC clock edges later (3000 at the defaults).
- R2: On the edge after pdown_pin_i is sampled high, reg_en_o, osc_en_o, lfo_en_o, tx_en_o, rx_en_o and ready_o are 0, and in_clamp_o and out_hiz_o are 1.
- R3: While in hard power-down, register writes, UART bytes and read requests have no effect: rd_ack_o stays 0. Leaving hard power-down returns the standby bit and the modem-off bit to 0.
- R4: On the edge that samples pdown_pin_i low in hard power-down, start-up begins. ready_o rises STARTUP_CYC edges after that edge.
- R5: A write of 1 to the standby bit (stby_we_i=1, stby_wdata_i=1) enters standby on that same edge. In standby lfo_en_o=1, reg_en_o=osc_en_o=ready_o=0, and in_clamp_o=out_hiz_o=0.
- R6: In standby, a write of 0 to the standby bit starts start-up. ready_o rises STARTUP_CYC edges after the write edge.
- R7: In standby, a UART byte equal to WAKE_BYTE (default 0x55) starts start-up with the same timing as R6. Any other byte leaves the block in standby.
- R8: A read request (rd_req_i=1) is acknowledged with rd_ack_o=1 on the next cycle only if ready_o was 1 when it was sampled. The returned rd_data_o is {6'b0, modem_off, standby}. rd_data_o holds its value when no read is acknowledged.
- R9: With the modem-off bit set, tx_en_o and rx_en_o are 0 while reg_en_o, osc_en_o and ready_o are not affected. Clearing the bit restores the transmitter and receiver enables in full operation.
- R10: pdown_pin_i takes priority: a standby write on the same edge as the pin going high leads to hard power-down, not to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdown_pin_i | input | 1 | Hard power-down request, active high |
| stby_we_i | input | 1 | Write strobe for the standby bit |
| stby_wdata_i | input | 1 | Value written to the standby bit |
| modem_we_i | input | 1 | Write strobe for the modem-off bit |
| modem_wdata_i | input | 1 | Value written to the modem-off bit |
| uart_valid_i | input | 1 | A received UART byte is present |
| uart_byte_i | input | 8 | Received UART byte |
| rd_req_i | input | 1 | Host read of the status address |
| rd_ack_o | output | 1 | Read answered, one cycle after the request |
| rd_data_o | output | 8 | Status byte returned by the read |
| reg_en_o | output | 1 | Core regulator enable |
| osc_en_o | output | 1 | Main oscillator enable |
| lfo_en_o | output | 1 | Low-frequency oscillator enable |
| in_clamp_o | output | 1 | Isolates and clamps the digital inputs |
| out_hiz_o | output | 1 | Puts the outputs in high impedance |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| ready_o | output | 1 | Full operation reached |

## Verification
The hardest case to reach from the ports is a change in hard power-down that leaves no visible trace: a modem-off bit set before the pin goes high, and writes and a wake byte sent while the pin is still high. The bench sets the modem-off bit in full operation, presses the pin, sends the ignored stimulus, releases the pin and waits for the full start-up count. It then checks that tx_en_o came back and that a status read returns zero, which shows both bits were cleared and the writes were dropped. Start-up lengths are measured one edge early and on the exact edge for every wake path.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_HARDPD = 2'd1,
    PS_STBY   = 2'd2,
    PS_WAKE   = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_startup_timer.sv
`timescale 1ns/1ps
module pwr_startup_timer #(
  parameter int unsigned CYCLES = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // reset counts as a start: the block boots through start-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= LOAD;
    else if (start_i)                cnt_q <= LOAD;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_host_if.sv
`timescale 1ns/1ps
module pwr_host_if #(
  parameter logic [7:0] WAKE_BYTE = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       in_stby_i,
  input  logic       uart_valid_i,
  input  logic [7:0] uart_byte_i,
  input  logic       rd_req_i,
  input  logic       ready_i,
  input  logic [7:0] status_i,
  output logic       uart_wake_o,
  output logic       rd_ack_o,
  output logic [7:0] rd_data_o
);
  assign uart_wake_o = in_stby_i && !pin_i && uart_valid_i && (uart_byte_i == WAKE_BYTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ack_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_ack_o <= rd_req_i && ready_i && !pin_i;
      if (rd_req_i && ready_i && !pin_i) rd_data_o <= status_i;
    end
  end

  a_r8_ack_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> $past(ready_i));
endmodule

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       stby_we_i,
  input  logic       stby_wdata_i,
  input  logic       modem_we_i,
  input  logic       modem_wdata_i,
  input  logic       uart_wake_i,
  input  logic       done_i,
  output pwr_state_e state_o,
  output logic       stby_o,
  output logic       modem_off_o,
  output logic       start_o
);
  pwr_state_e state_q, state_d;
  logic stby_q, modem_off_q;

  always_comb begin
    state_d = state_q;
    if (pin_i) state_d = PS_HARDPD;
    else begin
      unique case (state_q)
        PS_HARDPD: state_d = PS_WAKE;
        PS_RUN:    if (stby_we_i && stby_wdata_i) state_d = PS_STBY;
        PS_WAKE: begin
          if (stby_we_i && stby_wdata_i) state_d = PS_STBY;
          else if (done_i)               state_d = PS_RUN;
        end
        PS_STBY:   if ((stby_we_i && !stby_wdata_i) || uart_wake_i) state_d = PS_WAKE;
        default:   state_d = PS_HARDPD;
      endcase
    end
  end

  assign start_o = (state_d == PS_WAKE) && (state_q != PS_WAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_WAKE;
      stby_q      <= 1'b0;
      modem_off_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pin_i || state_q == PS_HARDPD) begin
        stby_q      <= 1'b0;
        modem_off_q <= 1'b0;
      end else begin
        if (stby_we_i)        stby_q <= stby_wdata_i;
        else if (uart_wake_i) stby_q <= 1'b0;
        if (modem_we_i)       modem_off_q <= modem_wdata_i;
      end
    end
  end

  assign state_o     = state_q;
  assign stby_o      = stby_q;
  assign modem_off_o = modem_off_q;

  a_r5_stby_same_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_i && (state_q == PS_RUN) && stby_we_i && stby_wdata_i) |=> (state_q == PS_STBY));
  a_r10_pin_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_i |=> (state_q == PS_HARDPD));
  a_r3_bits_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_HARDPD) |=> (!stby_q && !modem_off_q));
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned STARTUP_NS = 15000,
  parameter logic [7:0]  WAKE_BYTE  = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pdown_pin_i,
  input  logic       stby_we_i,
  input  logic       stby_wdata_i,
  input  logic       modem_we_i,
  input  logic       modem_wdata_i,
  input  logic       uart_valid_i,
  input  logic [7:0] uart_byte_i,
  input  logic       rd_req_i,
  output logic       rd_ack_o,
  output logic [7:0] rd_data_o,
  output logic       reg_en_o,
  output logic       osc_en_o,
  output logic       lfo_en_o,
  output logic       in_clamp_o,
  output logic       out_hiz_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       ready_o
);
  localparam int unsigned STARTUP_CYC = CLK_MHZ * STARTUP_NS / 1000;

  pwr_state_e state;
  logic stby, modem_off, start, done, uart_wake;

  pwr_startup_timer #(.CYCLES(STARTUP_CYC)) i_timer (
    .clk_i, .rst_ni,
    .start_i (start),
    .run_i   (state == PS_WAKE),
    .done_o  (done)
  );

  pwr_host_if #(.WAKE_BYTE(WAKE_BYTE)) i_host (
    .clk_i, .rst_ni,
    .pin_i        (pdown_pin_i),
    .in_stby_i    (state == PS_STBY),
    .uart_valid_i,
    .uart_byte_i,
    .rd_req_i,
    .ready_i      (ready_o),
    .status_i     ({6'b0, modem_off, stby}),
    .uart_wake_o  (uart_wake),
    .rd_ack_o,
    .rd_data_o
  );

  pwr_fsm i_fsm (
    .clk_i, .rst_ni,
    .pin_i        (pdown_pin_i),
    .stby_we_i,
    .stby_wdata_i,
    .modem_we_i,
    .modem_wdata_i,
    .uart_wake_i  (uart_wake),
    .done_i       (done),
    .state_o      (state),
    .stby_o       (stby),
    .modem_off_o  (modem_off),
    .start_o      (start)
  );

  always_comb begin
    reg_en_o   = 1'b0;
    osc_en_o   = 1'b0;
    lfo_en_o   = 1'b0;
    in_clamp_o = 1'b0;
    out_hiz_o  = 1'b0;
    ready_o    = 1'b0;
    unique case (state)
      PS_RUN:    begin reg_en_o = 1'b1; osc_en_o = 1'b1; lfo_en_o = 1'b1; ready_o = 1'b1; end
      PS_WAKE:   begin reg_en_o = 1'b1; osc_en_o = 1'b1; lfo_en_o = 1'b1; end
      PS_STBY:   lfo_en_o = 1'b1;
      PS_HARDPD: begin in_clamp_o = 1'b1; out_hiz_o = 1'b1; end
      default:   ;
    endcase
  end

  assign tx_en_o = (state == PS_RUN) && !modem_off;
  assign rx_en_o = (state == PS_RUN) && !modem_off;

  a_r2_pin_forces_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_pin_i |=> (in_clamp_o && out_hiz_o && !reg_en_o && !osc_en_o && !lfo_en_o && !ready_o));
  a_r9_radio_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o || rx_en_o) |-> (reg_en_o && osc_en_o));
endmodule

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
  localparam int unsigned N = 3000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pdown_pin_i = 0, stby_we_i = 0, stby_wdata_i = 0, modem_we_i = 0, modem_wdata_i = 0;
  logic uart_valid_i = 0, rd_req_i = 0;
  logic [7:0] uart_byte_i = 8'h00;
  logic rd_ack_o, reg_en_o, osc_en_o, lfo_en_o, in_clamp_o, out_hiz_o, tx_en_o, rx_en_o, ready_o;
  logic [7:0] rd_data_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk_i(clk), .rst_ni, .pdown_pin_i, .stby_we_i, .stby_wdata_i, .modem_we_i, .modem_wdata_i,
    .uart_valid_i, .uart_byte_i, .rd_req_i, .rd_ack_o, .rd_data_o, .reg_en_o, .osc_en_o,
    .lfo_en_o, .in_clamp_o, .out_hiz_o, .tx_en_o, .rx_en_o, .ready_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    stby_we_i = 0; stby_wdata_i = 0; modem_we_i = 0; modem_wdata_i = 0;
    uart_valid_i = 0; rd_req_i = 0;
  endtask

  // called right after the trigger edge has passed (one negedge after driving)
  task automatic expect_startup(input string req);
    repeat (N - 1) @(negedge clk);
    chk(req, "ready one edge early", ready_o, 0);
    chk(req, "regulator on in start-up", reg_en_o, 1);
    @(negedge clk);
    chk(req, "ready on count end", ready_o, 1);
  endtask

  task automatic t_reset();
    chk("R1", "reg_en after reset", reg_en_o, 1);
    chk("R1", "osc_en after reset", osc_en_o, 1);
    chk("R1", "lfo_en after reset", lfo_en_o, 1);
    chk("R1", "ready after reset", ready_o, 0);
    chk("R1", "clamp after reset", in_clamp_o, 0);
    repeat (N - 1) @(negedge clk);
    chk("R1", "ready one edge early", ready_o, 0);
    @(negedge clk);
    chk("R1", "ready at count end", ready_o, 1);
  endtask

  task automatic t_read_and_modem();
    rd_req_i = 1; @(negedge clk); idle();
    chk("R8", "ack when ready", rd_ack_o, 1);
    chk("R8", "status data", rd_data_o, 8'h00);
    @(negedge clk);
    chk("R8", "ack drops", rd_ack_o, 0);
    chk("R9", "tx on before modem off", tx_en_o, 1);
    modem_we_i = 1; modem_wdata_i = 1; @(negedge clk); idle();
    chk("R9", "tx off", tx_en_o, 0);
    chk("R9", "rx off", rx_en_o, 0);
    chk("R9", "regulator kept", reg_en_o, 1);
    chk("R9", "ready kept", ready_o, 1);
    rd_req_i = 1; @(negedge clk); idle();
    chk("R8", "status shows modem off", rd_data_o, 8'h02);
    modem_we_i = 1; modem_wdata_i = 0; @(negedge clk); idle();
    chk("R9", "rx restored", rx_en_o, 1);
  endtask

  task automatic enter_stby(input string req);
    stby_we_i = 1; stby_wdata_i = 1; @(negedge clk); idle();
    chk(req, "stby lfo", lfo_en_o, 1);
    chk(req, "stby reg off", reg_en_o, 0);
    chk(req, "stby osc off", osc_en_o, 0);
    chk(req, "stby not ready", ready_o, 0);
    chk(req, "stby no clamp", in_clamp_o, 0);
    chk(req, "stby no hiz", out_hiz_o, 0);
  endtask

  task automatic t_stby_bit_wake();
    enter_stby("R5");
    rd_req_i = 1; @(negedge clk); idle();
    chk("R8", "no ack in standby", rd_ack_o, 0);
    chk("R8", "data held", rd_data_o, 8'h02);
    stby_we_i = 1; stby_wdata_i = 0; @(negedge clk); idle();
    expect_startup("R6");
  endtask

  task automatic t_uart_wake();
    enter_stby("R5");
    uart_valid_i = 1; uart_byte_i = 8'hAA; @(negedge clk); idle();
    repeat (3) @(negedge clk);
    chk("R7", "other byte keeps standby", reg_en_o, 0);
    chk("R7", "other byte lfo", lfo_en_o, 1);
    uart_valid_i = 1; uart_byte_i = 8'h55; @(negedge clk); idle();
    expect_startup("R7");
  endtask

  task automatic t_hard_pd();
    modem_we_i = 1; modem_wdata_i = 1; @(negedge clk); idle();
    pdown_pin_i = 1; @(negedge clk);
    chk("R2", "clamp", in_clamp_o, 1);
    chk("R2", "hiz", out_hiz_o, 1);
    chk("R2", "reg off", reg_en_o, 0);
    chk("R2", "osc off", osc_en_o, 0);
    chk("R2", "lfo off", lfo_en_o, 0);
    chk("R2", "ready off", ready_o, 0);
    stby_we_i = 1; stby_wdata_i = 1; uart_valid_i = 1; uart_byte_i = 8'h55; rd_req_i = 1;
    @(negedge clk);
    chk("R3", "no ack in hard pd", rd_ack_o, 0);
    @(negedge clk); idle();
    chk("R3", "still clamped", in_clamp_o, 1);
    pdown_pin_i = 0; @(negedge clk);
    chk("R4", "clamp released", in_clamp_o, 0);
    expect_startup("R4");
    chk("R3", "modem bit cleared", tx_en_o, 1);
    rd_req_i = 1; @(negedge clk); idle();
    chk("R3", "status zero after pd", rd_data_o, 8'h00);
  endtask

  task automatic t_priority();
    pdown_pin_i = 1; stby_we_i = 1; stby_wdata_i = 1; @(negedge clk); idle();
    chk("R10", "pin wins clamp", in_clamp_o, 1);
    chk("R10", "pin wins lfo off", lfo_en_o, 0);
    pdown_pin_i = 0; @(negedge clk);
    expect_startup("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_read_and_modem();
    t_stby_bit_wake();
    t_uart_wake();
    t_hard_pd();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule